// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block turns a free-running master clock into a slower pixel clock for an image readout path. Each pixel period lasts a fixed base of two master clocks plus a programmable extension taken from a 5-bit speed field. Values above 21 are clamped to 21, so the longest period is 23 master clocks. At reset the speed is 0, and the pixel clock runs at half the master rate.

Alongside the clock, the block issues a one-cycle data-advance strobe once per period. The strobe marks the moment at which pixel data may change. A 4-bit phase field moves the pixel clock later against that strobe by a number of master clocks, reduced modulo the period. New speed and phase values are adopted only at a period boundary, so no pulse is cut short. Each time the adopted speed differs from the previous one, a change flag pulses. Downstream logic uses this flag to mark the frame in progress as unusable.

The speed and phase fields are plain level inputs that the block samples at period boundaries. There is no data stream at the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `pixclk_gen`

## Requirements
- R1: The pixel period is 2 + S master clocks, where S is the adopted speed. The data-advance strobe `adv_stb` repeats exactly every 2 + S cycles.
- R2: While `rst_n` is low, the adopted speed is 0 and the phase is 0. During reset, `pix_clk` = 1, `adv_stb` = 1 and `speed_chg` = 0. After release the period is 2.
- R3: A `speed_in` value above 21 is treated as 21, giving a period of 23. A value of exactly 21 also gives 23.
- R4: `speed_in` and `shift_in` are sampled only in the last cycle of a period. A change in the middle of a period leaves that period's length and waveform untouched.
- R5: Within each period of length P, `pix_clk` is high for ceil(P/2) consecutive master clocks and low for the remaining floor(P/2).
- R6: `adv_stb` is high for exactly one master clock per period, in the period's first cycle (count 0). Count 0 is where the unshifted pixel clock rises.
- R7: The pixel clock is delayed by D = `shift_in` mod P master clocks. With count c running 0..P-1 from the strobe, `pix_clk` is high when (c - D) mod P < ceil(P/2). It therefore rises D cycles after `adv_stb`.
- R8: `speed_chg` pulses for one master clock, in the first cycle of a period, when the newly adopted clamped speed differs from the one it replaces. Re-adopting the same value gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_in | input | 5 | Requested period extension in master clocks (clamped to 21) |
| shift_in | input | 4 | Requested delay of pix_clk relative to adv_stb, in master clocks |
| pix_clk | output | 1 | Generated pixel clock, registered |
| adv_stb | output | 1 | One-cycle strobe at the start of each pixel period |
| speed_chg | output | 1 | One-cycle pulse when a different speed is adopted |

## Verification
The speed-change pulse and the data-advance strobe must fall in the same master clock: the first cycle of the period that uses the new speed. A clamped-to-unclamped transition makes the phase shift and the new period length apply in that same cycle too. The bench provokes these coincidences by rewriting `speed_in` and `shift_in` in the middle of a period, including values above 21 and repeats of the current value. It judges each cycle against a behavioural model that adopts settings only at the period end. Separate interval measurements confirm that the period containing the write kept its old length.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  // Fixed part of every pixel period, in master clocks.
  localparam int BASE_PERIOD = 2;
  // Default field widths and limit.
  localparam int DEF_SPD_W   = 5;
  localparam int DEF_SHF_W   = 4;
  localparam int DEF_SPD_MAX = 21;

  // Registered output bundle of the shaper.
  typedef struct packed {
    logic clk;
    logic adv;
    logic chg;
  } pclk_out_t;
endpackage

// File: rtl/pclk_rate.sv
module pclk_rate #(
  parameter int SPD_W   = pclk_pkg::DEF_SPD_W,
  parameter int SPD_MAX = pclk_pkg::DEF_SPD_MAX,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPD_W-1:0] speed_in,
  input  logic             wrap,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] per_nxt,
  output logic             chg_nxt
);
  localparam logic [SPD_W-1:0] LIMIT = SPD_W'(SPD_MAX);
  localparam logic [CNT_W-1:0] BASE  = CNT_W'(pclk_pkg::BASE_PERIOD);

  logic [SPD_W-1:0] spd_lim;
  logic [CNT_W-1:0] per_cand;

  // Saturate the requested extension, then form the candidate period.
  always_comb begin
    spd_lim  = (speed_in > LIMIT) ? LIMIT : speed_in;
    per_cand = BASE + CNT_W'(spd_lim);
  end

  // Adopt only at the period end; flag a differing adoption.
  always_comb begin
    per_nxt = wrap ? per_cand : per_q;
    chg_nxt = wrap && (per_cand != per_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= BASE;
    else        per_q <= per_nxt;
  end
endmodule

// File: rtl/pclk_count.sv
module pclk_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  // Last cycle of the current period.
  always_comb begin
    wrap    = (cnt_q == per_q - CNT_W'(1));
    cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pclk_shape.sv
module pclk_shape #(
  parameter int SHF_W = pclk_pkg::DEF_SHF_W,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SHF_W-1:0] shift_in,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] per_nxt,
  input  logic             chg_nxt,
  output logic [CNT_W-1:0] sh_q,
  output pclk_pkg::pclk_out_t out_q
);
  localparam int PH_W      = CNT_W + 1;
  localparam int MOD_STEPS = (1 << SHF_W) / 2;
  localparam int WIDE_W    = (SHF_W > CNT_W) ? SHF_W : CNT_W;

  logic [CNT_W-1:0] sh_nxt;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  hi_len;
  logic             clk_nxt;

  // Reduce the shift modulo a period of at least two clocks.
  function automatic logic [CNT_W-1:0] reduce(input logic [SHF_W-1:0] s,
                                              input logic [CNT_W-1:0] p);
    logic [WIDE_W-1:0] r;
    r = WIDE_W'(s);
    for (int i = 0; i < MOD_STEPS; i++) begin
      if (r >= WIDE_W'(p)) r = r - WIDE_W'(p);
    end
    return CNT_W'(r);
  endfunction

  always_comb begin
    sh_nxt = wrap ? reduce(shift_in, per_nxt) : sh_q;
    if (cnt_nxt >= sh_nxt)
      ph = PH_W'(cnt_nxt) - PH_W'(sh_nxt);
    else
      ph = PH_W'(cnt_nxt) + PH_W'(per_nxt) - PH_W'(sh_nxt);
    hi_len  = (PH_W'(per_nxt) + PH_W'(1)) >> 1;
    clk_nxt = (ph < hi_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      out_q.clk <= 1'b1;
      out_q.adv <= 1'b1;
      out_q.chg <= 1'b0;
    end else begin
      sh_q      <= sh_nxt;
      out_q.clk <= clk_nxt;
      out_q.adv <= (cnt_nxt == '0);
      out_q.chg <= chg_nxt;
    end
  end
endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen #(
  parameter int SPD_W   = pclk_pkg::DEF_SPD_W,
  parameter int SHF_W   = pclk_pkg::DEF_SHF_W,
  parameter int SPD_MAX = pclk_pkg::DEF_SPD_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPD_W-1:0] speed_in,
  input  logic [SHF_W-1:0] shift_in,
  output logic             pix_clk,
  output logic             adv_stb,
  output logic             speed_chg
);
  localparam int CNT_W = $clog2(SPD_MAX + pclk_pkg::BASE_PERIOD + 1);

  logic [CNT_W-1:0] per_q, per_nxt, cnt_q, cnt_nxt, sh_q;
  logic             wrap, chg_nxt;
  pclk_pkg::pclk_out_t out_q;

  pclk_rate #(.SPD_W(SPD_W), .SPD_MAX(SPD_MAX), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .speed_in(speed_in), .wrap(wrap),
    .per_q(per_q), .per_nxt(per_nxt), .chg_nxt(chg_nxt)
  );

  pclk_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .per_q(per_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pclk_shape #(.SHF_W(SHF_W), .CNT_W(CNT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .per_nxt(per_nxt), .chg_nxt(chg_nxt),
    .sh_q(sh_q), .out_q(out_q)
  );

  assign pix_clk   = out_q.clk;
  assign adv_stb   = out_q.adv;
  assign speed_chg = out_q.chg;
endmodule

// File: rtl/pixclk_gen_chk.sv
module pixclk_gen_chk #(
  parameter int CNT_W   = 5,
  parameter int SPD_MAX = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_clk,
  input logic             adv_stb,
  input logic             speed_chg,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] sh_q
);
  localparam logic [CNT_W-1:0] PMAX = CNT_W'(SPD_MAX + 2);

  assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q);

  assert_period_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q <= PMAX) && (per_q >= CNT_W'(2)));

  assert_period_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> (cnt_q == '0));

  assert_adv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_stb |=> !adv_stb);

  assert_unshifted_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_stb && (sh_q == '0)) |-> pix_clk);

  assert_chg_with_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    speed_chg |-> adv_stb);

  assert_chg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    speed_chg |=> !speed_chg);
endmodule

bind pixclk_gen pixclk_gen_chk #(.CNT_W(CNT_W), .SPD_MAX(SPD_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .adv_stb(adv_stb),
  .speed_chg(speed_chg), .per_q(per_q), .cnt_q(cnt_q), .sh_q(sh_q)
);

// File: tb/pixclk_gen_test.sv
`timescale 1ns/1ps
module pixclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] speed_r = '0;
  logic [3:0] shift_r = '0;
  logic       pix_clk, adv_stb, speed_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  pixclk_gen uut (
    .clk(clk), .rst_n(rst_n), .speed_in(speed_r), .shift_in(shift_r),
    .pix_clk(pix_clk), .adv_stb(adv_stb), .speed_chg(speed_chg)
  );

  always #4 clk = ~clk;

  // Behavioural reference: period, shift, count, pending change flag.
  int m_cnt, m_per, m_sh;
  bit m_chg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_per <= 2; m_sh <= 0; m_chg <= 0;
    end else if (m_cnt == m_per - 1) begin
      int np;
      np = 2 + ((speed_r > 21) ? 21 : int'(speed_r));
      m_chg <= (np != m_per);
      m_per <= np;
      m_sh  <= int'(shift_r) % np;
      m_cnt <= 0;
    end else begin
      m_cnt <= m_cnt + 1;
      m_chg <= 0;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!done) begin
      bit e_clk;
      e_clk = (((m_cnt - m_sh + m_per) % m_per) < (m_per + 1) / 2);
      chk(pix_clk, e_clk, "R5 R7 pix_clk");
      chk(adv_stb, (m_cnt == 0), "R6 adv_stb");
      chk(speed_chg, m_chg, "R8 speed_chg");
    end
  end

  task automatic wait_adv();
    do @(negedge clk); while (!adv_stb);
  endtask

  task automatic gap(output int n);
    wait_adv();
    n = 0;
    do begin @(negedge clk); n++; end while (!adv_stb);
  endtask

  task automatic rise_ofs(output int n);
    logic prev;
    wait_adv();
    prev = pix_clk;
    n = 0;
    forever begin
      @(negedge clk); n++;
      if (pix_clk && !prev) break;
      prev = pix_clk;
    end
  endtask

  task automatic high_len(output int n);
    do @(negedge clk); while (!(pix_clk === 1'b0));
    do @(negedge clk); while (!(pix_clk === 1'b1));
    n = 0;
    while (pix_clk === 1'b1) begin n++; @(negedge clk); end
  endtask

  initial begin
    int g, pulses;
    repeat (4) @(negedge clk);
    // R2: outputs held during reset
    n_chk++; if (!(pix_clk === 1 && adv_stb === 1 && speed_chg === 0)) begin
      n_fail++;
      $display("FAIL R2 reset outputs got=%0b%0b%0b exp=110", pix_clk, adv_stb, speed_chg);
    end
    rst_n = 1'b1;
    gap(g); chk_int(g, 2, "R2 default period");

    speed_r = 5'd3;
    gap(g); gap(g); chk_int(g, 5, "R1 period speed 3");
    high_len(g); chk_int(g, 3, "R5 high length P=5");

    speed_r = 5'd31;
    gap(g); gap(g); chk_int(g, 23, "R3 clamp of 31");
    speed_r = 5'd21;
    gap(g); chk_int(g, 23, "R3 exact 21");

    speed_r = 5'd9;
    gap(g); gap(g); chk_int(g, 11, "R1 period speed 9");

    // R4: change mid-period, current period keeps old length
    wait_adv();
    repeat (3) @(negedge clk);
    speed_r = 5'd0; shift_r = 4'd1;
    g = 3;
    do begin @(negedge clk); g++; end while (!adv_stb);
    chk_int(g, 11, "R4 old period kept");
    gap(g); chk_int(g, 2, "R4 new period adopted");

    speed_r = 5'd4; shift_r = 4'd2;
    gap(g); gap(g);
    rise_ofs(g); chk_int(g, 2, "R7 shift 2 P=6");
    high_len(g); chk_int(g, 3, "R5 high length P=6");

    speed_r = 5'd1; shift_r = 4'd7;
    gap(g); gap(g);
    rise_ofs(g); chk_int(g, 1, "R7 shift 7 mod 3");
    high_len(g); chk_int(g, 2, "R5 high length P=3");

    speed_r = 5'd30; shift_r = 4'd15;
    gap(g); gap(g);
    rise_ofs(g); chk_int(g, 15, "R7 shift 15 P=23");

    // R8: one pulse on a real change, none on a repeat
    shift_r = 4'd0;
    speed_r = 5'd9;
    pulses = 0;
    repeat (60) begin @(negedge clk); if (speed_chg) pulses++; end
    chk_int(pulses, 1, "R8 single change pulse");
    speed_r = 5'd9;
    pulses = 0;
    repeat (60) begin @(negedge clk); if (speed_chg) pulses++; end
    chk_int(pulses, 0, "R8 repeat gives no pulse");
    speed_r = 5'd25;
    pulses = 0;
    repeat (60) begin @(negedge clk); if (speed_chg) pulses++; end
    speed_r = 5'd21;
    repeat (60) begin @(negedge clk); if (speed_chg) pulses++; end
    chk_int(pulses, 1, "R8 R3 clamped equal value");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule